// File: doc/BRIEF.md
# Prioritised External Interrupt Controller

This block collects level-sensitive interrupt requests from up to 31 devices and delivers them to a small number of hart contexts. Every source has a programmable priority. Every context has its own per-source enable mask and a priority threshold. A context's interrupt line is high while some pending source is enabled for it and ranks strictly above its threshold.

Software services an interrupt in two steps through a word-addressed register port. A claim read returns the best eligible source for that context and takes it out of the pending set. A completion write with the same source number re-arms the source. Between those two steps the source cannot be signalled again, even if its request line stays high. This gives each device a clean one-shot handshake per service round.

Source number 0 is reserved and means "nothing to claim". Bus accesses are accepted every cycle, and read data returns one cycle after the read.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Each source n (1..NUM_SRC) has a priority register at byte address 4·n that holds PRIO_W bits and reads back as written (upper write bits dropped). A source whose priority is 0 never raises any context line.
- R2: Each context c has an enable word at 0x100 + 0x40·c, where bit n enables source n. A source whose bit is clear never raises that context's line and is never returned by that context's claim.
- R3: Each context c has a threshold at 0x200 + 0x20·c. A pending, enabled source is deliverable only when its priority is strictly greater than the threshold.
- R4: `ext_irq[c]` is high exactly while at least one source is deliverable to context c. With no source pending, every line is low.
- R5: A read of 0x204 + 0x20·c returns the deliverable source with the highest priority. Ties go to the lowest source number. The read returns 0 when nothing is deliverable.
- R6: A claim that returns source n clears its pending bit in the same cycle. Source n stays not-pending while it is claimed, whatever its request line does.
- R7: Writing n to 0x204 + 0x20·c ends the claim on n only if context c holds it; any other completion is ignored. After a valid completion, a still-high request makes n pending again one cycle later.
- R8: The word at 0x080 reports pending source n in bit n; bit 0 always reads 0.
- R9: `bus_ready` is always high, and `bus_rvalid` pulses exactly one cycle after each accepted read, with `bus_rdata` valid in that cycle. Misaligned or unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Level request; bit k belongs to source k+1 |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Access accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| ext_irq | output | NUM_CTX | Interrupt line per context |

## Verification
The bench builds the block with seven sources, two contexts and a 2-bit priority. With these values every priority/threshold pair (16 combinations) can be swept exhaustively on one source. Eight computed priority patterns over all seven sources drain the claim order to empty, which covers ties, priority-0 sources and the empty claim. The second context makes wrong-owner completions and mask isolation observable.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PRIO,
        RK_PEND,
        RK_EN,
        RK_THR,
        RK_CLAIM
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [4:0] idx;
        logic [3:0] ctx;
    } reg_sel_t;

    // Address decode: priorities 0x000-0x07C, pending word 0x080,
    // enables 0x100 + 0x40*ctx, threshold/claim 0x200 + 0x20*ctx.
    function automatic reg_sel_t decode_addr(logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.idx  = a[6:2];
        s.ctx  = '0;
        if (a[1:0] == 2'b00) begin
            if (a[9:7] == 3'b000) begin
                s.kind = RK_PRIO;
            end else if (a[9:2] == 8'h20) begin
                s.kind = RK_PEND;
            end else if (a[9:8] == 2'b01 && a[5:2] == 4'h0) begin
                s.kind = RK_EN;
                s.ctx  = {2'b00, a[7:6]};
            end else if (a[9] && a[4:3] == 2'b00) begin
                s.ctx  = a[8:5];
                s.kind = a[2] ? RK_CLAIM : RK_THR;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
    parameter int CTX_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             claim,
    input  logic [CTX_W-1:0] claim_ctx,
    input  logic             cmpl,
    input  logic [CTX_W-1:0] cmpl_ctx,
    output logic             pend,
    output logic             busy
);

    logic [CTX_W-1:0] owner_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            busy    <= 1'b0;
            owner_q <= '0;
        end else if (claim) begin
            pend    <= 1'b0;
            busy    <= 1'b1;
            owner_q <= claim_ctx;
        end else if (cmpl && busy && owner_q == cmpl_ctx) begin
            busy <= 1'b0;
        end else if (req && !busy) begin
            pend <= 1'b1;
        end
    end

endmodule

// File: rtl/ctx_select.sv
module ctx_select #(
    parameter int NUM_SRC = 31,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 5
) (
    input  logic [NUM_SRC:1]             elig,
    input  logic [NUM_SRC:1][PRIO_W-1:0] prio,
    output logic [ID_W-1:0]              best_id
);

    logic [PRIO_W-1:0] best_p;

    // Scan from the top id down; ">=" lets a lower id take a tie.
    always_comb begin
        best_id = '0;
        best_p  = '0;
        for (int i = NUM_SRC; i >= 1; i--) begin
            if (elig[i] && prio[i] >= best_p) begin
                best_id = ID_W'(i);
                best_p  = prio[i];
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = 31,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  irq_req,
    input  logic                bus_valid,
    output logic                bus_ready,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic                bus_rvalid,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_CTX-1:0]  ext_irq
);

    localparam int ID_W  = $clog2(NUM_SRC + 1);
    localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

    logic [NUM_SRC:1][PRIO_W-1:0]  prio_q;
    logic [NUM_CTX-1:0][NUM_SRC:1] en_q;
    logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q;
    logic [NUM_SRC:1]              pend_vec;
    logic [NUM_SRC:1]              busy_vec;
    logic [NUM_CTX-1:0][NUM_SRC:1] elig;
    logic [NUM_CTX-1:0][ID_W-1:0]  best_id;

    reg_sel_t          sel;
    logic              ctx_ok;
    logic [CTX_W-1:0]  sel_ctx;
    logic              claim_fire;
    logic              cmpl_fire;
    logic [ID_W-1:0]   claim_id;
    logic [DATA_W-1:0] rd_data;

    assign bus_ready  = 1'b1;
    assign sel        = decode_addr(bus_addr);
    assign ctx_ok     = (32'(sel.ctx) < NUM_CTX);
    assign sel_ctx    = sel.ctx[CTX_W-1:0];
    assign claim_fire = bus_valid && !bus_write && sel.kind == RK_CLAIM && ctx_ok;
    assign cmpl_fire  = bus_valid &&  bus_write && sel.kind == RK_CLAIM && ctx_ok;

    // Per-context eligibility and winner
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        for (genvar i = 1; i <= NUM_SRC; i++) begin : g_elig
            assign elig[c][i] = pend_vec[i] && en_q[c][i] && (prio_q[i] > thr_q[c]);
        end
        ctx_select #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W),
            .ID_W    (ID_W)
        ) u_sel (
            .elig    (elig[c]),
            .prio    (prio_q),
            .best_id (best_id[c])
        );
        assign ext_irq[c] = (best_id[c] != '0);
    end

    always_comb begin
        claim_id = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (sel.ctx == 4'(c)) claim_id = best_id[c];
        end
    end

    // Per-source claim/complete gateways
    for (genvar i = 1; i <= NUM_SRC; i++) begin : g_src
        irq_gateway #(.CTX_W(CTX_W)) u_gw (
            .clk       (clk),
            .rst       (rst),
            .req       (irq_req[i-1]),
            .claim     (claim_fire && claim_id == ID_W'(i)),
            .claim_ctx (sel_ctx),
            .cmpl      (cmpl_fire && bus_wdata == DATA_W'(i)),
            .cmpl_ctx  (sel_ctx),
            .pend      (pend_vec[i]),
            .busy      (busy_vec[i])
        );
    end

    // Configuration writes
    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (bus_valid && bus_write) begin
            case (sel.kind)
                RK_PRIO: begin
                    for (int i = 1; i <= NUM_SRC; i++) begin
                        if (sel.idx == 5'(i)) prio_q[i] <= bus_wdata[PRIO_W-1:0];
                    end
                end
                RK_EN: begin
                    for (int c = 0; c < NUM_CTX; c++) begin
                        if (sel.ctx == 4'(c)) en_q[c] <= bus_wdata[NUM_SRC:1];
                    end
                end
                RK_THR: begin
                    for (int c = 0; c < NUM_CTX; c++) begin
                        if (sel.ctx == 4'(c)) thr_q[c] <= bus_wdata[PRIO_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    // Read mux
    always_comb begin
        rd_data = '0;
        case (sel.kind)
            RK_PRIO: begin
                for (int i = 1; i <= NUM_SRC; i++) begin
                    if (sel.idx == 5'(i)) rd_data = DATA_W'(prio_q[i]);
                end
            end
            RK_PEND: rd_data[NUM_SRC:1] = pend_vec;
            RK_EN: begin
                for (int c = 0; c < NUM_CTX; c++) begin
                    if (sel.ctx == 4'(c)) rd_data[NUM_SRC:1] = en_q[c];
                end
            end
            RK_THR: begin
                for (int c = 0; c < NUM_CTX; c++) begin
                    if (sel.ctx == 4'(c)) rd_data = DATA_W'(thr_q[c]);
                end
            end
            RK_CLAIM: if (ctx_ok) rd_data = DATA_W'(claim_id);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_valid && !bus_write;
            if (bus_valid && !bus_write) bus_rdata <= rd_data;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NUM_SRC = 31,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_CTX-1:0] ext_irq,
    input logic [NUM_SRC:1]   pend_vec,
    input logic [NUM_SRC:1]   busy_vec,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [9:0]         bus_addr,
    input logic               bus_rvalid,
    input logic [31:0]        bus_rdata
);

    // R6
    pend_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_vec & busy_vec) == '0);

    // R4
    idle_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        pend_vec == '0 |-> ext_irq == '0);

    // R9
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(bus_valid && !bus_write));

    // R8
    pend_bit0_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_write && bus_addr == 10'h080 |=> bus_rdata[0] == 1'b0);

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_c
        // R5
        claim_empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
            bus_valid && !bus_write && bus_addr == 10'(32'h204 + 32 * c) && !ext_irq[c]
            |=> bus_rdata == 32'h0);
        // R6
        claim_takes_chk: assert property (@(posedge clk) disable iff (rst)
            bus_valid && !bus_write && bus_addr == 10'(32'h204 + 32 * c) && ext_irq[c]
            |=> bus_rdata != 32'h0 && busy_vec != '0);
    end

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .PRIO_W  (PRIO_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ext_irq    (ext_irq),
    .pend_vec   (pend_vec),
    .busy_vec   (busy_vec),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

    localparam int NS = 7;
    localparam int NC = 2;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] irq_req = '0;
    logic          bus_valid = 1'b0;
    logic          bus_ready;
    logic          bus_write = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rvalid;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] ext_irq;

    int checks = 0;
    int fails  = 0;
    int mprio [1:NS];
    bit mpend [1:NS];

    always #2 clk = ~clk;

    irq_prio_ctrl #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(PW)) u_irq_prio_ctrl (
        .clk (clk), .rst (rst), .irq_req (irq_req),
        .bus_valid (bus_valid), .bus_ready (bus_ready), .bus_write (bus_write),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rvalid (bus_rvalid), .bus_rdata (bus_rdata), .ext_irq (ext_irq)
    );

    function automatic logic [9:0] a_prio(int n); return 10'(4 * n); endfunction
    function automatic logic [9:0] a_en(int c);   return 10'(32'h100 + 32'h40 * c); endfunction
    function automatic logic [9:0] a_thr(int c);  return 10'(32'h200 + 32'h20 * c); endfunction
    function automatic logic [9:0] a_clm(int c);  return 10'(32'h204 + 32'h20 * c); endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
        checks++;
        if (bus_rvalid !== 1'b1) begin
            fails++;
            $display("FAIL R9 rvalid got %0b exp 1", bus_rvalid);
        end
    endtask

    // Bench model: highest priority, lowest id, eligible for ctx0 with threshold 0
    function automatic int best_model();
        int b = 0;
        int bp = 0;
        for (int i = NS; i >= 1; i--) begin
            if (mpend[i] && mprio[i] > 0 && mprio[i] >= bp) begin
                b = i; bp = mprio[i];
            end
        end
        return b;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // Reset state
        chk("R4 reset lines", 32'(ext_irq), 32'h0);
        rd(a_clm(0), d); chk("R5 reset claim", d, 32'h0);
        rd(10'h080, d);  chk("R8 reset pending", d, 32'h0);
        rd(a_prio(3), d); chk("R1 reset prio", d, 32'h0);
        chk("R9 ready", 32'(bus_ready), 32'h1);
        rd(10'h082, d);  chk("R9 misaligned read", d, 32'h0);

        // R1 readback with masking
        for (int i = 1; i <= NS; i++) wr(a_prio(i), 32'hFFFF_FFF0 | 32'(i % 4));
        for (int i = 1; i <= NS; i++) begin
            rd(a_prio(i), d); chk("R1 prio readback", d, 32'(i % 4));
        end

        // R3 exhaustive priority/threshold sweep on source 3, ctx0 only
        wr(a_en(0), 32'h0000_0008);
        wr(a_en(1), 32'h0);
        irq_req[2] = 1'b1;
        @(negedge clk);
        rd(10'h080, d); chk("R8 pending bit 3", d, 32'h8);
        for (int p = 0; p < 4; p++) begin
            for (int t = 0; t < 4; t++) begin
                wr(a_prio(3), 32'(p));
                wr(a_thr(0), 32'(t));
                chk("R3 R1 threshold sweep", 32'(ext_irq[0]), 32'(p > t));
                chk("R2 ctx1 masked", 32'(ext_irq[1]), 32'h0);
            end
        end
        wr(a_prio(3), 32'h1);
        wr(a_thr(0), 32'h0);
        chk("R4 thr0 prio1", 32'(ext_irq[0]), 32'h1);
        rd(a_clm(1), d); chk("R2 ctx1 claim masked", d, 32'h0);
        rd(a_clm(0), d); chk("R5 claim src3", d, 32'h3);
        irq_req[2] = 1'b0;
        wr(a_clm(0), 32'h3);

        // R2 enable on ctx1 only
        wr(a_en(0), 32'h0);
        wr(a_en(1), 32'h0000_0008);
        irq_req[2] = 1'b1;
        @(negedge clk);
        chk("R2 ctx1 line", 32'(ext_irq), 32'h2);
        rd(a_clm(0), d); chk("R2 ctx0 claim empty", d, 32'h0);
        rd(a_clm(1), d); chk("R5 ctx1 claim", d, 32'h3);
        repeat (2) @(negedge clk);
        rd(10'h080, d); chk("R6 held request not pending", d, 32'h0);
        chk("R6 line low after claim", 32'(ext_irq), 32'h0);
        wr(a_clm(0), 32'h3);  // wrong context
        wr(a_clm(1), 32'h5);  // not claimed
        @(negedge clk);
        rd(10'h080, d); chk("R7 bogus completions ignored", d, 32'h0);
        wr(a_clm(1), 32'h3);
        @(negedge clk);
        rd(10'h080, d); chk("R7 rearm after completion", d, 32'h8);
        chk("R7 line back", 32'(ext_irq), 32'h2);
        irq_req[2] = 1'b0;
        rd(a_clm(1), d); chk("R5 ctx1 reclaim", d, 32'h3);
        wr(a_clm(1), 32'h3);

        // R5 arbitration patterns on ctx0
        wr(a_en(0), 32'h0000_00FE);
        wr(a_en(1), 32'h0);
        wr(a_thr(0), 32'h0);
        for (int k = 0; k < 8; k++) begin
            for (int i = 1; i <= NS; i++) begin
                mprio[i] = (i * k + k / 2) % 4;
                mpend[i] = 1'b1;
                wr(a_prio(i), 32'(mprio[i]));
            end
            irq_req = '1;
            @(negedge clk);
            for (int n = 0; n <= NS; n++) begin
                int e;
                e = best_model();
                chk("R4 line vs model", 32'(ext_irq[0]), 32'(e != 0));
                rd(a_clm(0), d); chk("R5 arbitration", d, 32'(e));
                if (e != 0) mpend[e] = 1'b0;
            end
            irq_req = '0;
            for (int i = 1; i <= NS; i++) begin
                if (!mpend[i]) wr(a_clm(0), 32'(i));
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule